// File: doc/BRIEF.md
# Unfairness-Driven Source Throttling Controller

This block decides, once per measurement interval, how hard each core may push on the shared memory system. An interval-end strobe makes it take a snapshot of three inputs: a per-core slowdown estimate, a matrix of how much each core delayed every other core, and a fairness target. From the snapshot it finds the core with the worst slowdown and the core that interfered with it the most. If the spread between the worst and the best slowdown is larger than the target, the victim gains one throttle level and the interferer loses one.

Each core carries a 3-bit throttle level. A higher level means more freedom. Every level maps to two limits that the core's request logic enforces: a cap on outstanding requests and a minimum gap between injected requests. The decision has a fixed latency. A one-cycle done pulse marks the cycle in which the new levels first appear, and they hold until the next decision. The slowdown and interference estimators sit outside this block and reach it as plain inputs.

Top module: `fair_throttle`

## Requirements
- R1: After reset every core is at level 4, so maxOutstanding is 9 and injectGap is 3, and done is low.
- R2: Say intervalEnd is sampled high on a rising edge while the block is idle. Then done goes high for exactly one cycle after the third following rising edge. Levels change only on that edge and hold between decisions.
- R3: targetIn is unsigned fixed point with 4 fractional bits, so 8'h20 means 2.0. The interval counts as unfair only when maxSlowdown × 16 > targetIn × minSlowdown. Equality counts as fair, and a fair interval leaves all levels unchanged.
- R4: The slowest core is the one with the largest slowdownIn field. Core c's field sits at bits [c*8 +: 8]. Ties go to the lowest index. In an unfair interval the slowest core's level rises by one and saturates at 7.
- R5: The interferer is the aggressor index a that has the largest entry in the slowest core's row. Entry (victim v, aggressor a) sits at interfIn bits [(v*4+a)*8 +: 8]. Ties go to the lowest index. In an unfair interval the interferer's level falls by one and saturates at 0.
- R6: No level changes if the interferer is the slowest core itself, or if every entry in the slowest core's row is zero.
- R7: For each core c, levelOut[c*3 +: 3] is its level. maxOutstanding[c*4 +: 4] equals 2×level+1, and injectGap[c*3 +: 3] equals 7−level.
- R8: An intervalEnd that arrives while a decision is in progress is ignored. It starts no second decision and causes no extra done pulse.
- R9: The decision uses only the inputs sampled on the intervalEnd edge. Input changes after that edge do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intervalEnd | input | 1 | Marks the end of a measurement interval |
| slowdownIn | input | 32 | Per-core slowdown estimates, 8 bits per core |
| interfIn | input | 128 | Interference matrix, 8 bits per victim/aggressor pair |
| targetIn | input | 8 | Unfairness target, 4 fractional bits |
| levelOut | output | 12 | Per-core throttle level, 3 bits per core |
| maxOutstanding | output | 16 | Per-core outstanding-request cap, 4 bits per core |
| injectGap | output | 12 | Per-core minimum cycles between injections, 3 bits per core |
| done | output | 1 | One-cycle pulse when new levels are valid |

## Verification
The bench targets the following corner cases:

- **Unfairness equal to the target.** A design using >= instead of > would throttle at this point.
- **Tied slowdowns and tied interference entries.** Picking the highest index would move the wrong cores.
- **Saturation at both ends of the level range.** A design without saturation would wrap 7 to 0 or 0 to 7.
- **Self-interference and an all-zero row.** A careless design would throttle the victim, or throttle core 0 for nothing.
- **Repeated intervalEnd and inputs that change in mid-decision.** These expose a design that restarts while busy or reads live inputs instead of the snapshot.

The done latency is measured on every decision.

// File: rtl/fair_throttle_pkg.sv
package fair_throttle_pkg;

  // Phases of one throttling decision
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCAN  = 2'd1,
    PH_PICK  = 2'd2,
    PH_APPLY = 2'd3
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // snapshot inputs
    logic scan;     // register slowest core and slowdown extremes
    logic pick;     // register interferer and fairness verdict
    logic apply;    // update levels
  } strobe_t;

endpackage

// File: rtl/fair_throttle_ctrl.sv
module fair_throttle_ctrl
  import fair_throttle_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    intervalEnd,
  output strobe_t strb,
  output logic    done
);

  phase_t phase;

  always_comb begin
    strb.capture = (phase == PH_IDLE) && intervalEnd;
    strb.scan    = (phase == PH_SCAN);
    strb.pick    = (phase == PH_PICK);
    strb.apply   = (phase == PH_APPLY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strb.apply;
      unique case (phase)
        PH_IDLE:  if (intervalEnd) phase <= PH_SCAN;
        PH_SCAN:  phase <= PH_PICK;
        PH_PICK:  phase <= PH_APPLY;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.capture, strb.scan, strb.pick, strb.apply}));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // While a decision runs, a new interval end cannot restart it
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> (phase != PH_SCAN));

endmodule

// File: rtl/fair_throttle_dp.sv
module fair_throttle_dp
  import fair_throttle_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int SD_W        = 8,
  parameter int INTF_W      = 8,
  parameter int TGT_W       = 8,
  parameter int TGT_FRAC    = 4,
  parameter int LVL_W       = 3,
  parameter int RESET_LEVEL = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  strobe_t                              strb,
  input  logic [NUM_CORES*SD_W-1:0]            slowdownIn,
  input  logic [NUM_CORES*NUM_CORES*INTF_W-1:0] interfIn,
  input  logic [TGT_W-1:0]                     targetIn,
  output logic [NUM_CORES-1:0][LVL_W-1:0]      levels
);

  localparam int IDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int PROD_W  = SD_W + TGT_W;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  // Snapshot taken at the interval end
  logic [NUM_CORES-1:0][SD_W-1:0]                  sdCap;
  logic [NUM_CORES-1:0][NUM_CORES-1:0][INTF_W-1:0] intfCap;
  logic [TGT_W-1:0]                                tgtCap;

  // Scan results
  logic [IDX_W-1:0] slowIdx, slowIdxNext;
  logic [SD_W-1:0]  maxSd, maxSdNext, minSd, minSdNext;

  // Pick results
  logic [IDX_W-1:0]  aggIdx, aggIdxNext;
  logic [INTF_W-1:0] aggMaxNext;
  logic              act, actNext;
  logic [PROD_W-1:0] lhs, rhs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdCap   <= '0;
      intfCap <= '0;
      tgtCap  <= '0;
    end else if (strb.capture) begin
      for (int v = 0; v < NUM_CORES; v++) begin
        sdCap[v] <= slowdownIn[v*SD_W +: SD_W];
        for (int a = 0; a < NUM_CORES; a++)
          intfCap[v][a] <= interfIn[(v*NUM_CORES+a)*INTF_W +: INTF_W];
      end
      tgtCap <= targetIn;
    end
  end

  // Slowest core (first maximum) and smallest slowdown
  always_comb begin
    slowIdxNext = '0;
    maxSdNext   = sdCap[0];
    minSdNext   = sdCap[0];
    for (int c = 1; c < NUM_CORES; c++) begin
      if (sdCap[c] > maxSdNext) begin
        maxSdNext   = sdCap[c];
        slowIdxNext = IDX_W'(c);
      end
      if (sdCap[c] < minSdNext) minSdNext = sdCap[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slowIdx <= '0;
      maxSd   <= '0;
      minSd   <= '0;
    end else if (strb.scan) begin
      slowIdx <= slowIdxNext;
      maxSd   <= maxSdNext;
      minSd   <= minSdNext;
    end
  end

  // Worst interferer in the slowest core's row, and fairness test without division
  always_comb begin
    aggIdxNext = '0;
    aggMaxNext = intfCap[slowIdx][0];
    for (int a = 1; a < NUM_CORES; a++) begin
      if (intfCap[slowIdx][a] > aggMaxNext) begin
        aggMaxNext = intfCap[slowIdx][a];
        aggIdxNext = IDX_W'(a);
      end
    end
    lhs     = PROD_W'(maxSd) << TGT_FRAC;
    rhs     = PROD_W'(tgtCap) * PROD_W'(minSd);
    actNext = (lhs > rhs) && (aggIdxNext != slowIdx) && (aggMaxNext != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aggIdx <= '0;
      act    <= 1'b0;
    end else if (strb.pick) begin
      aggIdx <= aggIdxNext;
      act    <= actNext;
    end
  end

  // Saturating level update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CORES; c++) levels[c] <= LVL_W'(RESET_LEVEL);
    end else if (strb.apply && act) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (IDX_W'(c) == slowIdx && levels[c] != LVL_W'(LVL_MAX))
          levels[c] <= levels[c] + LVL_W'(1);
        else if (IDX_W'(c) == aggIdx && levels[c] != '0)
          levels[c] <= levels[c] - LVL_W'(1);
      end
    end
  end

  assert_levels_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.apply |=> $stable(levels));

  assert_fair_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.apply && !act) |=> $stable(levels));

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_step
      assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (levels[g] != $past(levels[g])) |->
          ((levels[g] == $past(levels[g]) + LVL_W'(1)) ||
           (levels[g] == $past(levels[g]) - LVL_W'(1))));
    end
  endgenerate

endmodule

// File: rtl/fair_throttle.sv
module fair_throttle
  import fair_throttle_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int SD_W        = 8,
  parameter int INTF_W      = 8,
  parameter int TGT_W       = 8,
  parameter int TGT_FRAC    = 4,
  parameter int LVL_W       = 3,
  parameter int RESET_LEVEL = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  intervalEnd,
  input  logic [NUM_CORES*SD_W-1:0]             slowdownIn,
  input  logic [NUM_CORES*NUM_CORES*INTF_W-1:0] interfIn,
  input  logic [TGT_W-1:0]                      targetIn,
  output logic [NUM_CORES*LVL_W-1:0]            levelOut,
  output logic [NUM_CORES*(LVL_W+1)-1:0]        maxOutstanding,
  output logic [NUM_CORES*LVL_W-1:0]            injectGap,
  output logic                                  done
);

  localparam int LVL_MAX = (1 << LVL_W) - 1;

  strobe_t                          strb;
  logic [NUM_CORES-1:0][LVL_W-1:0]  levels;

  fair_throttle_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .intervalEnd (intervalEnd),
    .strb        (strb),
    .done        (done)
  );

  fair_throttle_dp #(
    .NUM_CORES   (NUM_CORES),
    .SD_W        (SD_W),
    .INTF_W      (INTF_W),
    .TGT_W       (TGT_W),
    .TGT_FRAC    (TGT_FRAC),
    .LVL_W       (LVL_W),
    .RESET_LEVEL (RESET_LEVEL)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .slowdownIn (slowdownIn),
    .interfIn   (interfIn),
    .targetIn   (targetIn),
    .levels     (levels)
  );

  // Level to request-limit mapping
  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_map
      assign levelOut[c*LVL_W +: LVL_W]              = levels[c];
      assign maxOutstanding[c*(LVL_W+1) +: LVL_W+1]  = {levels[c], 1'b1};
      assign injectGap[c*LVL_W +: LVL_W]             = LVL_W'(LVL_MAX) - levels[c];
    end
  endgenerate

  assert_change_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (levelOut != $past(levelOut)) |-> done);

endmodule

// File: tb/fair_throttle_bench.sv
`timescale 1ns/1ps
module fair_throttle_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         intervalEnd;
  logic [31:0]  slowdownIn;
  logic [127:0] interfIn;
  logic [7:0]   targetIn;
  logic [11:0]  levelOut;
  logic [15:0]  maxOutstanding;
  logic [11:0]  injectGap;
  logic         done;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fair_throttle u_fair_throttle (
    .clk            (clk),
    .rst_n          (rst_n),
    .intervalEnd    (intervalEnd),
    .slowdownIn     (slowdownIn),
    .interfIn       (interfIn),
    .targetIn       (targetIn),
    .levelOut       (levelOut),
    .maxOutstanding (maxOutstanding),
    .injectGap      (injectGap),
    .done           (done)
  );

  // {slowdowns c3..c0, row a3..a0 (same for all victims), target, levels c3..c0}
  localparam logic [83:0] VECS [0:8] = '{
    {32'h1414280A, 32'h071E0005, 8'h20, 3'd4, 3'd3, 3'd5, 3'd4}, // R4 R5 unfair
    {32'h1414280A, 32'h071E0005, 8'h20, 3'd4, 3'd2, 3'd6, 3'd4}, // R4 R5 again
    {32'h14281414, 32'h09000000, 8'h20, 3'd4, 3'd2, 3'd6, 3'd4}, // R3 equality is fair
    {32'h320A0A0A, 32'h00010303, 8'h20, 3'd5, 3'd2, 3'd6, 3'd3}, // R5 tie -> lowest
    {32'h0A3C0A0A, 32'h00000000, 8'h20, 3'd5, 3'd2, 3'd6, 3'd3}, // R6 zero row
    {32'h0A0A0A3C, 32'h01010109, 8'h20, 3'd5, 3'd2, 3'd6, 3'd3}, // R6 self
    {32'h1E0A1E0A, 32'h04040000, 8'h18, 3'd5, 3'd1, 3'd7, 3'd3}, // R4 tie -> lowest
    {32'h1E0A1E0A, 32'h04040000, 8'h18, 3'd5, 3'd0, 3'd7, 3'd3}, // R4 saturate high
    {32'h1E0A1E0A, 32'h04040000, 8'h18, 3'd5, 3'd0, 3'd7, 3'd3}  // R5 saturate low
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setInputs(input logic [31:0] sd, input logic [31:0] row, input logic [7:0] tgt);
    slowdownIn = sd;
    targetIn   = tgt;
    for (int v = 0; v < 4; v++) interfIn[v*32 +: 32] = row;
  endtask

  task automatic checkLevels(input logic [11:0] exp, input string req);
    for (int c = 0; c < 4; c++) begin
      int lv;
      lv = int'(exp[c*3 +: 3]);
      chk(levelOut[c*3 +: 3] == exp[c*3 +: 3], req, int'(levelOut[c*3 +: 3]), lv);
      chk(maxOutstanding[c*4 +: 4] == 4'(2*lv+1), "R7 maxOutstanding",
          int'(maxOutstanding[c*4 +: 4]), 2*lv+1);
      chk(injectGap[c*3 +: 3] == 3'(7-lv), "R7 injectGap", int'(injectGap[c*3 +: 3]), 7-lv);
    end
  endtask

  // Pulse intervalEnd once, measure done latency; optionally alter inputs after capture
  task automatic runDecision(input bit alter);
    int n;
    @(negedge clk) intervalEnd = 1'b1;
    @(negedge clk) intervalEnd = 1'b0;
    if (alter) slowdownIn = 32'h0A0A0A0A;
    n = 0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R2 done latency", n, 3);
  endtask

  initial begin
    int pulses;
    rst_n = 1'b0;
    intervalEnd = 1'b0;
    setInputs(32'h0, 32'h0, 8'h20);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(done == 1'b0, "R1 done", int'(done), 0);
    checkLevels({3'd4, 3'd4, 3'd4, 3'd4}, "R1 reset level");

    // Vector table
    for (int i = 0; i < 9; i++) begin
      setInputs(VECS[i][83:52], VECS[i][51:20], VECS[i][19:12]);
      runDecision(1'b0);
      checkLevels(VECS[i][11:0], "R3 R4 R5 R6 vector levels");
      @(negedge clk);
      chk(done == 1'b0, "R2 done one cycle", int'(done), 0);
    end

    // R8: intervalEnd held across the busy phases
    setInputs(32'h320A0A0A, 32'h00000001, 8'h20);
    pulses = 0;
    @(negedge clk) intervalEnd = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 1) intervalEnd = 1'b0;
      if (done) pulses++;
    end
    chk(pulses == 1, "R8 single done", pulses, 1);
    checkLevels({3'd6, 3'd0, 3'd7, 3'd2}, "R8 one update only");

    // R9: inputs changed after capture do not matter
    setInputs(32'h0A0A0A32, 32'h00000100, 8'h20);
    runDecision(1'b1);
    checkLevels({3'd6, 3'd0, 3'd6, 3'd3}, "R9 snapshot");

    // R2: levels hold with no interval end
    repeat (5) @(negedge clk);
    checkLevels({3'd6, 3'd0, 3'd6, 3'd3}, "R2 hold");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule